// File: doc/BRIEF.md
# Luminance Trap and Peaking Path

This block conditions an 8-bit video sample stream at one sample per clock, for a nominal 13.5 MHz sample rate. The input may be a composite signal or a luminance signal that has already been separated. Each sample passes through four stages in order:

- an optional high-frequency boost that makes up for cable and source loss;
- a three-tap notch that removes the colour subcarrier, tuned to either 4.43 MHz or 3.58 MHz, or skipped entirely for separated Y/C sources;
- a peaking stage that picks one of two band-pass shapes, scales the result by a programmable amount and adds it onto the unpeaked signal;
- a final scaling stage that brings the DC gain back to exactly one whatever the notch setting, then rounds and clamps the result to 8 bits.

Samples enter and leave on a valid/ready stream. Back-pressure works as follows. `in_ready` is high whenever the output register is empty or the consumer is taking its word. When `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `out_data` is held. Filter history advances only on samples that were actually accepted, so idle cycles and stalls do not change the results.

The mode pins are plain levels. They are sampled only on an accepted sample that carries `line_start`. From that sample on, every output is computed with the new settings, so a setting never changes in the middle of a video line.

Top module: `luma_enh`

## Requirements
- R1: An input sample transfers on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. Every accepted sample yields exactly one output word, and output words come out in input order.
- R2: Latency counted in samples is fixed at 6 for every mode. Number the accepted samples x[0], x[1], … and the output words y[0], y[1], …. Then y[m] is the filtered value centred on x[m-6].
- R3: With `emph_on`=1, the first stage computes (10·x[c] − x[c−1] − x[c+1])/8 around the centre sample c. With `emph_on`=0 it passes x[c] through unchanged.
- R4: With `notch_skip`=0 and `notch_ntsc`=0, the notch computes (87·p[c−1] + 82·p[c] + 87·p[c+1])/256, which has a null near 4.43 MHz. A 4.43 MHz sine then leaves the output within ±3 of its mean.
- R5: With `notch_skip`=0 and `notch_ntsc`=1, the notch uses the taps (117, 22, 117)/256, which have a null near 3.58 MHz.
- R6: With `notch_skip`=1 the notch stage is a pure delay. With the boost off and `peak_gain`=0, y[m] equals x[m−6] exactly.
- R7: The peaking stage outputs t[c] + `peak_gain`·bp/8, where `peak_gain` is a 4-bit value from 0 to 15. With `peak_low`=0, bp = 2t[c] − t[c−2] − t[c+2], which peaks at fs/4. With `peak_low`=1, bp = 2t[c] − t[c−4] − t[c+4], which peaks at fs/8.
- R8: A constant input produces that same constant at the output in every combination of modes.
- R9: All intermediate sums are exact. The final division rounds halves upward, and the result is clamped to the range 0 to 255.
- R10: The mode pins are taken only on an accepted sample with `line_start`=1. Outputs y[m] for m at or after that sample's index use the new settings, and changes on the pins at any other time have no effect.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, all filter history is zero and the settings are all-zero: boost off, notch at 4.43 MHz, peaking off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 8 | Unsigned input sample |
| line_start | input | 1 | Marks the first sample of a line; mode pins are captured with it |
| emph_on | input | 1 | 1 enables the high-frequency boost |
| notch_skip | input | 1 | 1 bypasses the subcarrier notch |
| notch_ntsc | input | 1 | 0 selects the 4.43 MHz notch, 1 selects the 3.58 MHz notch |
| peak_low | input | 1 | 0 selects the fs/4 band, 1 selects the fs/8 band |
| peak_gain | input | 4 | Peaking amount in eighths |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 8 | Rounded and clamped output sample |

## Verification
Random data with the notch bypassed separates a true pure delay from any stage that alters the signal, and it also exposes the zero history left by reset. Sines at 4.43 MHz and 3.58 MHz, fed through the matching notch and through the other notch, show which centre frequency was selected. An alternating pattern at the Nyquist rate measures the boost gain, hits the clamp at both rails and checks the round-half-up rule. A period-four pattern tells the two peaking bands apart, because only the fs/4 band responds to it. Constant inputs over every mode combination confirm unity DC gain. A mid-line pin change followed by a later `line_start` shows that settings change only at the line boundary. Every stream runs with random input gaps and output stalls.

// File: rtl/luma_pkg.sv
package luma_pkg;
  localparam int GAIN_W  = 4;
  localparam int EMPH_SH = 3;   // boost taps sum to 8
  localparam int NOTCH_SH = 8;  // notch taps sum to 256
  localparam int PEAK_SH = 3;   // peaking amount in eighths
  localparam int TOTAL_SH = EMPH_SH + NOTCH_SH + PEAK_SH;

  typedef struct packed {
    logic skip;
    logic ntsc;
  } notch_mode_t;

  typedef struct packed {
    logic              low;
    logic [GAIN_W-1:0] gain;
  } peak_mode_t;

  typedef struct packed {
    logic        emph;
    notch_mode_t notch;
    peak_mode_t  peak;
  } luma_cfg_t;
endpackage

// File: rtl/luma_emph.sv
module luma_emph #(
  parameter int XW = 8,
  parameter int PW = XW + 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vin,
  input  logic [XW-1:0]        din,
  input  logic                 on,
  output logic                 vout,
  output logic signed [PW-1:0] dout
);
  logic [XW-1:0] h1, h2;
  logic signed [PW-1:0] nw, ct, od, boost, flat;

  assign nw    = $signed({{(PW-XW){1'b0}}, din});
  assign ct    = $signed({{(PW-XW){1'b0}}, h1});
  assign od    = $signed({{(PW-XW){1'b0}}, h2});
  assign boost = (ct <<< 3) + (ct <<< 1) - nw - od;
  assign flat  = ct <<< 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1   <= '0;
      h2   <= '0;
      vout <= 1'b0;
      dout <= '0;
    end else if (adv) begin
      vout <= vin;
      if (vin) begin
        h1   <= din;
        h2   <= h1;
        dout <= on ? boost : flat;
      end
    end
  end
endmodule

// File: rtl/luma_notch.sv
module luma_notch #(
  parameter int PW      = 13,
  parameter int TW      = PW + 9,
  parameter int SH      = 8,
  parameter int EDGE_HI = 87,
  parameter int MID_HI  = 82,
  parameter int EDGE_LO = 117,
  parameter int MID_LO  = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vin,
  input  logic signed [PW-1:0] din,
  input  logic                 skip,
  input  logic                 ntsc,
  output logic                 vout,
  output logic signed [TW-1:0] dout
);
  logic signed [PW-1:0] h1, h2;
  logic signed [TW-1:0] a_n, a_c, a_o, e_k, m_k, notched, passed;

  assign a_n     = TW'(din);
  assign a_c     = TW'(h1);
  assign a_o     = TW'(h2);
  assign e_k     = ntsc ? TW'(EDGE_LO) : TW'(EDGE_HI);
  assign m_k     = ntsc ? TW'(MID_LO)  : TW'(MID_HI);
  assign notched = e_k * (a_n + a_o) + m_k * a_c;
  assign passed  = a_c <<< SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1   <= '0;
      h2   <= '0;
      vout <= 1'b0;
      dout <= '0;
    end else if (adv) begin
      vout <= vin;
      if (vin) begin
        h1   <= din;
        h2   <= h1;
        dout <= skip ? passed : notched;
      end
    end
  end
endmodule

// File: rtl/luma_peak.sv
module luma_peak #(
  parameter int TW   = 22,
  parameter int QW   = TW + 7,
  parameter int KW   = 4,
  parameter int SH   = 3,
  parameter int HALF = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vin,
  input  logic signed [TW-1:0] din,
  input  logic                 low,
  input  logic [KW-1:0]        gain,
  output logic                 vout,
  output logic signed [QW-1:0] dout
);
  localparam int DL   = 2 * HALF;
  localparam int MIDO = HALF / 2;

  logic signed [TW-1:0] dl [DL];
  logic signed [QW-1:0] ctr, near_a, near_b, far_a, far_b, bp, kk, q;

  // tap line holding the last DL accepted samples, newest in dl[0]
  generate
    for (genvar g = 0; g < DL; g++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n) dl[g] <= '0;
        else if (adv && vin) dl[g] <= (g == 0) ? din : dl[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ctr    = QW'(dl[HALF-1]);
  assign near_a = QW'(dl[HALF-MIDO-1]);
  assign near_b = QW'(dl[HALF+MIDO-1]);
  assign far_a  = QW'(din);
  assign far_b  = QW'(dl[DL-1]);
  assign bp     = (ctr <<< 1) - (low ? (far_a + far_b) : (near_a + near_b));
  assign kk     = QW'($signed({1'b0, gain}));
  assign q      = (ctr <<< SH) + kk * bp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (adv) begin
      vout <= vin;
      if (vin) dout <= q;
    end
  end
endmodule

// File: rtl/luma_enh.sv
module luma_enh
  import luma_pkg::*;
#(
  parameter int XW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XW-1:0]     in_data,
  input  logic              line_start,
  input  logic              emph_on,
  input  logic              notch_skip,
  input  logic              notch_ntsc,
  input  logic              peak_low,
  input  logic [GAIN_W-1:0] peak_gain,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XW-1:0]     out_data
);
  localparam int PW = XW + 5;
  localparam int TW = PW + NOTCH_SH + 1;
  localparam int QW = TW + 7;
  localparam logic signed [QW-1:0] HALF_LSB = QW'(2 ** (TOTAL_SH - 1));
  localparam logic signed [QW-1:0] TOP_VAL  = QW'((2 ** XW) - 1);

  logic adv, take;
  luma_cfg_t pins, live_q, cur;
  notch_mode_t nm_1;
  peak_mode_t  pm_1, pm_2;

  logic v1, v2, v3;
  logic signed [PW-1:0] d1;
  logic signed [TW-1:0] d2;
  logic signed [QW-1:0] d3, biased, scaled;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;
  assign pins     = '{emph: emph_on, notch: '{skip: notch_skip, ntsc: notch_ntsc},
                      peak: '{low: peak_low, gain: peak_gain}};
  assign cur      = (in_valid && line_start) ? pins : live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      nm_1   <= '0;
      pm_1   <= '0;
      pm_2   <= '0;
    end else begin
      if (take && line_start) live_q <= pins;
      if (adv) begin
        nm_1 <= cur.notch;
        pm_1 <= cur.peak;
        pm_2 <= pm_1;
      end
    end
  end

  luma_emph #(.XW(XW), .PW(PW)) u_emph (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(in_valid), .din(in_data),
    .on(cur.emph), .vout(v1), .dout(d1));

  luma_notch #(.PW(PW), .TW(TW), .SH(NOTCH_SH)) u_notch (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(v1), .din(d1),
    .skip(nm_1.skip), .ntsc(nm_1.ntsc), .vout(v2), .dout(d2));

  luma_peak #(.TW(TW), .QW(QW), .KW(GAIN_W), .SH(PEAK_SH)) u_peak (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(v2), .din(d2),
    .low(pm_2.low), .gain(pm_2.gain), .vout(v3), .dout(d3));

  assign biased = d3 + HALF_LSB;
  assign scaled = biased >>> TOTAL_SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= v3;
      if (v3) begin
        if (scaled < 0)            out_data <= '0;
        else if (scaled > TOP_VAL) out_data <= TOP_VAL[XW-1:0];
        else                       out_data <= scaled[XW-1:0];
      end
    end
  end
endmodule

// File: rtl/luma_enh_chk.sv
module luma_enh_chk
  import luma_pkg::*;
#(
  parameter int XW = 8,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          line_start,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_data,
  input luma_cfg_t     live_cfg
);
  localparam int CW = $clog2(DEPTH + 2) + 1;
  logic [CW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != '0);

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && line_start) |=> $stable(live_cfg));
endmodule

bind luma_enh luma_enh_chk #(.XW(XW), .DEPTH(4)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .line_start(line_start), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .live_cfg(live_q));

// File: tb/luma_enh_test.sv
module luma_enh_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, line_start = 1'b0;
  logic [7:0] in_data = '0;
  logic emph_on = 1'b0, notch_skip = 1'b0, notch_ntsc = 1'b0, peak_low = 1'b0;
  logic [3:0] peak_gain = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  int xs [0:255];
  int ys [0:255];
  logic [7:0] cfgs [0:255];   // {emph, skip, ntsc, low, gain[3:0]}
  bit ls [0:255];
  bit stall_on = 1'b1;
  // model settings
  bit me, msk, mnt, mlo;
  int mk;

  always #4 clk = ~clk;

  luma_enh uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .line_start(line_start), .emph_on(emph_on),
    .notch_skip(notch_skip), .notch_ntsc(notch_ntsc), .peak_low(peak_low),
    .peak_gain(peak_gain), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic longint pv(int j);
    if (me) return 10 * xs[j-1] - xs[j] - xs[j-2];
    return 8 * xs[j-1];
  endfunction

  function automatic longint tv(int j);
    longint e, c;
    if (msk) return 256 * pv(j-1);
    e = mnt ? 117 : 87;
    c = mnt ? 22 : 82;
    return e * (pv(j) + pv(j-2)) + c * pv(j-1);
  endfunction

  function automatic int model(int m);
    longint q, bp, r;
    if (mlo) bp = 2 * tv(m-4) - tv(m) - tv(m-8);
    else     bp = 2 * tv(m-4) - tv(m-2) - tv(m-6);
    q = 8 * tv(m-4) + longint'(mk) * bp;
    r = (q + 8192) >>> 14;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  function automatic logic [7:0] mkcfg(bit e, bit s, bit n, bit l, int k);
    return {e, s, n, l, k[3:0]};
  endfunction

  task automatic set_model(logic [7:0] c);
    me = c[7]; msk = c[6]; mnt = c[5]; mlo = c[4]; mk = int'(c[3:0]);
  endtask

  task automatic fill_cfg(int n, logic [7:0] c);
    for (int i = 0; i < n; i++) begin
      cfgs[i] = c;
      ls[i] = (i == 0);
    end
  endtask

  // streams xs[0..n-1] through the block, collecting ys[0..n-1]
  task automatic run(int n);
    int ii = 0, oo = 0;
    while (oo < n) begin
      @(negedge clk);
      out_ready = stall_on ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (ii < n && (!stall_on || $urandom_range(0, 4) != 0)) begin
        in_valid = 1'b1;
        in_data = xs[ii][7:0];
        line_start = ls[ii];
        {emph_on, notch_skip, notch_ntsc, peak_low, peak_gain} = cfgs[ii];
      end else begin
        in_valid = 1'b0;
        line_start = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        ys[oo] = int'(out_data);
        oo++;
      end
      if (in_valid && in_ready) ii++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    line_start = 1'b0;
    out_ready = 1'b1;
  endtask

  task automatic check_model(int lo, int hi, string req);
    for (int m = lo; m < hi; m++) chk(ys[m] == model(m), req, ys[m], model(m));
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_pure_delay();
    for (int i = 0; i < 64; i++) xs[i] = $urandom_range(0, 255);
    fill_cfg(64, mkcfg(0, 1, 0, 0, 0));
    run(64);
    for (int m = 0; m < 6; m++) chk(ys[m] == 0, "R11 zero history", ys[m], 0);
    for (int m = 6; m < 64; m++) chk(ys[m] == xs[m-6], "R6 R2 R1 pure delay", ys[m], xs[m-6]);
  endtask

  task automatic t_emph();
    logic [7:0] c = mkcfg(1, 1, 0, 0, 0);
    set_model(c);
    for (int i = 0; i < 40; i++) xs[i] = (i % 2 == 0) ? 148 : 108;
    fill_cfg(40, c);
    run(40);
    for (int m = 16; m < 40; m++)
      chk(ys[m] == (((m-6) % 2 == 0) ? 158 : 98), "R3 boost gain", ys[m], ((m-6) % 2 == 0) ? 158 : 98);
    check_model(16, 40, "R3 model");
    for (int i = 0; i < 40; i++) xs[i] = (i % 2 == 0) ? 3 : 1;
    run(40);
    for (int m = 16; m < 40; m++)
      chk(ys[m] == (((m-6) % 2 == 0) ? 4 : 1), "R9 round half up", ys[m], ((m-6) % 2 == 0) ? 4 : 1);
    for (int i = 0; i < 40; i++) xs[i] = (i % 2 == 0) ? 255 : 0;
    run(40);
    for (int m = 16; m < 40; m++)
      chk(ys[m] == (((m-6) % 2 == 0) ? 255 : 0), "R9 clamp", ys[m], ((m-6) % 2 == 0) ? 255 : 0);
  endtask

  task automatic t_notch(bit ntsc, real f, string req);
    int dev;
    logic [7:0] c;
    for (int i = 0; i < 96; i++)
      xs[i] = $rtoi(128.0 + 100.0 * $sin(2.0 * 3.14159265358979 * f * i / 13.5) + 128.5) - 128;
    c = mkcfg(0, 0, ntsc, 0, 0);
    set_model(c);
    fill_cfg(96, c);
    run(96);
    check_model(16, 96, req);
    for (int m = 16; m < 96; m++) begin
      dev = ys[m] - 128;
      chk(dev <= 3 && dev >= -3, {req, " notch depth"}, ys[m], 128);
    end
    // the other notch leaves this tone largely intact
    c = mkcfg(0, 0, !ntsc, 0, 0);
    set_model(c);
    fill_cfg(96, c);
    run(96);
    check_model(16, 96, {req, " other notch"});
    dev = 0;
    for (int m = 16; m < 96; m++) if ((ys[m] - 128) > dev) dev = ys[m] - 128;
    chk(dev > 20, {req, " selectivity"}, dev, 21);
  endtask

  task automatic t_peak();
    logic [7:0] c = mkcfg(0, 1, 0, 0, 2);
    int pat [4] = '{148, 128, 108, 128};
    int pk  [4] = '{168, 128, 88, 128};
    for (int i = 0; i < 48; i++) xs[i] = pat[i % 4];
    set_model(c);
    fill_cfg(48, c);
    run(48);
    for (int m = 16; m < 48; m++) chk(ys[m] == pk[(m-6) % 4], "R7 fs/4 band", ys[m], pk[(m-6) % 4]);
    c = mkcfg(0, 1, 0, 1, 15);
    fill_cfg(48, c);
    run(48);
    for (int m = 16; m < 48; m++) chk(ys[m] == xs[m-6], "R7 fs/8 band null at fs/4", ys[m], xs[m-6]);
    for (int i = 0; i < 64; i++) xs[i] = $urandom_range(60, 200);
    c = mkcfg(1, 0, 1, 1, 9);
    set_model(c);
    fill_cfg(64, c);
    run(64);
    check_model(16, 64, "R7 R2 mixed model");
  endtask

  task automatic t_dc();
    int combo = 0, v;
    for (int e = 0; e < 2; e++)
      for (int t = 0; t < 3; t++)
        for (int l = 0; l < 2; l++) begin
          v = (combo == 0) ? 0 : (combo == 11) ? 255 : (17 + 23 * combo) % 256;
          for (int i = 0; i < 24; i++) xs[i] = v;
          fill_cfg(24, mkcfg(e[0], t == 2, t == 1, l[0], 15));
          run(24);
          for (int m = 16; m < 24; m++) chk(ys[m] == v, "R8 unity DC", ys[m], v);
          combo++;
        end
  endtask

  task automatic t_boundary();
    logic [7:0] ca = mkcfg(0, 1, 0, 0, 0);
    logic [7:0] cb = mkcfg(0, 0, 0, 0, 0);
    for (int i = 0; i < 96; i++) begin
      xs[i] = (i % 2 == 0) ? 148 : 108;
      cfgs[i] = (i < 30) ? ca : cb;
      ls[i] = (i == 0) || (i == 60);
    end
    run(96);
    for (int m = 16; m < 60; m++) chk(ys[m] == xs[m-6], "R10 mid-line change ignored", ys[m], xs[m-6]);
    set_model(cb);
    check_model(72, 96, "R10 new settings after line start");
    chk(ys[80] != xs[74], "R10 notch active", ys[80], xs[74]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pure_delay();
    t_emph();
    t_notch(1'b0, 4.43, "R4");
    t_notch(1'b1, 3.58, "R5");
    t_peak();
    stall_on = 1'b0;
    t_dc();
    stall_on = 1'b1;
    t_dc();
    t_boundary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule